// File: doc/BRIEF.md
# Index-Domain Residue Multiplier

This block forms the product of a residue and a filter coefficient modulo a small prime `MODULUS` (17 to 61). It never multiplies. A nonzero operand is first turned into its discrete logarithm with respect to a primitive root `PRIM_ROOT`. That exponent is then added to the coefficient's exponent modulo `MODULUS-1`. An exponentiation table turns the sum back into a residue. Both tables are computed at elaboration from the two parameters.

The coefficient arrives already in exponent form, with a separate flag for a zero coefficient. Changing the coefficient therefore touches no table. Zero has no logarithm. A zero operand or a flagged zero coefficient is detected in the first stage and clears the product in the second stage. The block is meant as one multiplier inside one channel of a residue-arithmetic datapath. It accepts one operation per cycle and returns each result two cycles later.

Top module: `rns_idx_mult`

## Requirements
- R1: For a nonzero operand `a` below `MODULUS`, a clear `in_czero` and a coefficient exponent `c` below `MODULUS-1`, `out_res` equals `(a * PRIM_ROOT^c) mod MODULUS`, and that value is nonzero.
- R2: An accepted operand of value 0 yields `out_res` = 0, whatever the coefficient exponent is.
- R3: An accepted operation with `in_czero` = 1 yields `out_res` = 0, whatever the operand and the exponent are.
- R4: `out_vld` is high exactly two clock cycles after the cycle in which `in_vld` was high. Operations may be issued on every cycle.
- R5: When no result is delivered, `out_res` keeps the value of the last delivered result.
- R6: While `rst` is high at a rising edge, both `out_vld` and `out_res` are 0 after that edge.
- R7: A coefficient exponent of 0 with `in_czero` = 0 returns the operand unchanged.
- R8: When the operand's exponent plus `c` reaches `MODULUS-1` or more, the sum wraps modulo `MODULUS-1` and the product is still correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operation request for this cycle |
| in_res | input | $clog2(MODULUS) | Operand residue, below MODULUS |
| in_cidx | input | $clog2(MODULUS-1) | Coefficient exponent, below MODULUS-1 |
| in_czero | input | 1 | Coefficient is zero |
| out_vld | output | 1 | Result delivered this cycle |
| out_res | output | $clog2(MODULUS) | Product residue |

## Verification
The bench runs four moduli side by side (17, 31, 37 and 61). For each one it applies every operand against every coefficient exponent, back to back. This covers the exponent sums that wrap past `MODULUS-1`: an adder that forgot the wrap, or reduced by `MODULUS` instead, would give wrong residues on roughly half the pairs. Zero operands and flagged coefficients are mixed in with random gaps in `in_vld`. A design that looked up zero in the log table would return a nonzero power of the root. A design that updated its output on idle cycles would lose the held result. Exponent 0 checks the identity case, and an off-by-one in the table build would show up there first.

// File: rtl/idxmul_pkg.sv
package idxmul_pkg;

    // Modular power by repeated multiplication, used only for constant tables.
    function automatic int pow_mod(input int base, input int expo, input int modulus);
        int acc;
        acc = 1;
        for (int i = 0; i < expo; i++) begin
            acc = (acc * base) % modulus;
        end
        return acc;
    endfunction

    // Largest exponent that a nonzero residue can have.
    function automatic int max_exponent(input int modulus);
        return modulus - 2;
    endfunction

endpackage

// File: rtl/idxmul_log_rom.sv
module idxmul_log_rom #(
    parameter int MODULUS   = 61,
    parameter int PRIM_ROOT = 2,
    localparam int RW = $clog2(MODULUS),
    localparam int IW = $clog2(MODULUS - 1),
    localparam int ENTRIES = 2 ** RW
) (
    input  logic [RW-1:0] res_i,
    output logic [IW-1:0] idx_o
);
    import idxmul_pkg::*;

    function automatic logic [ENTRIES*IW-1:0] build_log();
        logic [ENTRIES*IW-1:0] tbl;
        int r;
        tbl = '0;
        for (int e = 0; e <= max_exponent(MODULUS); e++) begin
            r = pow_mod(PRIM_ROOT, e, MODULUS);
            tbl[r*IW +: IW] = IW'(e);
        end
        return tbl;
    endfunction

    localparam logic [ENTRIES*IW-1:0] LOG_TBL = build_log();

    always_comb begin
        idx_o = LOG_TBL[int'(res_i)*IW +: IW];
    end

endmodule

// File: rtl/idxmul_exp_rom.sv
module idxmul_exp_rom #(
    parameter int MODULUS   = 61,
    parameter int PRIM_ROOT = 2,
    localparam int RW = $clog2(MODULUS),
    localparam int IW = $clog2(MODULUS - 1),
    localparam int ENTRIES = 2 ** IW
) (
    input  logic [IW-1:0] idx_i,
    output logic [RW-1:0] res_o
);
    import idxmul_pkg::*;

    function automatic logic [ENTRIES*RW-1:0] build_exp();
        logic [ENTRIES*RW-1:0] tbl;
        tbl = '0;
        for (int e = 0; e <= max_exponent(MODULUS); e++) begin
            tbl[e*RW +: RW] = RW'(pow_mod(PRIM_ROOT, e, MODULUS));
        end
        return tbl;
    endfunction

    localparam logic [ENTRIES*RW-1:0] EXP_TBL = build_exp();

    always_comb begin
        res_o = EXP_TBL[int'(idx_i)*RW +: RW];
    end

endmodule

// File: rtl/idxmul_modadd.sv
module idxmul_modadd #(
    parameter int MODULUS = 61,
    localparam int IW = $clog2(MODULUS - 1)
) (
    input  logic [IW-1:0] a_i,
    input  logic [IW-1:0] b_i,
    output logic [IW-1:0] sum_o
);
    localparam logic [IW:0] ORDER = (IW + 1)'(MODULUS - 1);

    logic [IW:0] raw;

    always_comb begin
        raw = {1'b0, a_i} + {1'b0, b_i};
        if (raw >= ORDER) begin
            sum_o = IW'(raw - ORDER);
        end else begin
            sum_o = raw[IW-1:0];
        end
    end

    // Reduced sum of two legal exponents stays a legal exponent (wrap, R8).
    always_comb begin
        if ({1'b0, a_i} < ORDER && {1'b0, b_i} < ORDER) begin
            assert_sum_in_range_R8: assert ({1'b0, sum_o} < ORDER);
        end
    end

endmodule

// File: rtl/rns_idx_mult.sv
module rns_idx_mult #(
    parameter int MODULUS   = 61,
    parameter int PRIM_ROOT = 2,
    localparam int RW = $clog2(MODULUS),
    localparam int IW = $clog2(MODULUS - 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [RW-1:0] in_res,
    input  logic [IW-1:0] in_cidx,
    input  logic          in_czero,
    output logic          out_vld,
    output logic [RW-1:0] out_res
);

    typedef struct packed {
        logic          s1_vld;
        logic          s1_zero;
        logic [IW-1:0] s1_ia;
        logic [IW-1:0] s1_ic;
        logic          o_vld;
        logic [RW-1:0] o_res;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [IW-1:0] opd_idx;
    logic [IW-1:0] sum_idx;
    logic [RW-1:0] pow_res;

    idxmul_log_rom #(.MODULUS(MODULUS), .PRIM_ROOT(PRIM_ROOT)) u_log (
        .res_i (in_res),
        .idx_o (opd_idx)
    );

    idxmul_modadd #(.MODULUS(MODULUS)) u_add (
        .a_i   (pipe_q.s1_ia),
        .b_i   (pipe_q.s1_ic),
        .sum_o (sum_idx)
    );

    idxmul_exp_rom #(.MODULUS(MODULUS), .PRIM_ROOT(PRIM_ROOT)) u_exp (
        .idx_i (sum_idx),
        .res_o (pow_res)
    );

    always_comb begin
        pipe_d = pipe_q;
        // Stage 1: forward lookup and zero detect.
        pipe_d.s1_vld = in_vld;
        if (in_vld) begin
            pipe_d.s1_zero = (in_res == '0) || in_czero;
            pipe_d.s1_ia   = opd_idx;
            pipe_d.s1_ic   = in_cidx;
        end
        // Stage 2: exponent sum, inverse lookup, clear on zero.
        pipe_d.o_vld = pipe_q.s1_vld;
        if (pipe_q.s1_vld) begin
            pipe_d.o_res = pipe_q.s1_zero ? '0 : pow_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_vld = pipe_q.o_vld;
    assign out_res = pipe_q.o_res;

    assert_issue_to_result_R4: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> ##1 out_vld);

    assert_no_spurious_result_R4: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ##1 !out_vld);

    assert_zero_operand_R2: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_res == '0) |=> ##1 (out_res == '0));

    assert_zero_coef_R3: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_czero) |=> ##1 (out_res == '0));

    assert_nonzero_product_R1: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_res != '0 && !in_czero) |=> ##1
        (out_res != '0 && int'(out_res) < MODULUS));

    assert_identity_coef_R7: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_czero && in_cidx == '0) |=> ##1 (out_res == $past(in_res, 2)));

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !pipe_q.s1_vld |=> $stable(out_res));

endmodule

// File: tb/test_rns_idx_mult.sv
module test_rns_idx_mult;

    localparam int CLK_PERIOD = 10;
    localparam int NI = 4;
    localparam int MODS  [NI] = '{17, 31, 37, 61};
    localparam int ROOTS [NI] = '{3, 3, 2, 2};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic       b_vld  [NI];
    logic [5:0] b_opd  [NI];
    logic [5:0] b_cidx [NI];
    logic       b_cz   [NI];
    logic       b_ovld [NI];
    logic [5:0] b_prod [NI];

    for (genvar k = 0; k < NI; k++) begin : g_dut
        localparam int MK  = MODS[k];
        localparam int GK  = ROOTS[k];
        localparam int RWK = $clog2(MK);
        localparam int IWK = $clog2(MK - 1);
        logic [RWK-1:0] res_w;
        logic           vld_w;
        rns_idx_mult #(.MODULUS(MK), .PRIM_ROOT(GK)) i_rns_idx_mult (
            .clk      (clk),
            .rst      (rst),
            .in_vld   (b_vld[k]),
            .in_res   (b_opd[k][RWK-1:0]),
            .in_cidx  (b_cidx[k][IWK-1:0]),
            .in_czero (b_cz[k]),
            .out_vld  (vld_w),
            .out_res  (res_w)
        );
        assign b_ovld[k] = vld_w;
        assign b_prod[k] = 6'(res_w);
    end

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Staged stimulus and bench-side model pipeline.
    int    s_vld [NI], s_a [NI], s_c [NI], s_cz [NI];
    int    p1_v [NI], p1_e [NI], p2_v [NI], p2_e [NI], held [NI];
    string p1_t [NI], p2_t [NI];

    function automatic int f_pow(input int g, input int e, input int m);
        int r = 1;
        for (int i = 0; i < e; i++) r = (r * g) % m;
        return r;
    endfunction

    function automatic int f_log(input int r, input int g, input int m);
        for (int e = 0; e < m - 1; e++) if (f_pow(g, e, m) == r) return e;
        return 0;
    endfunction

    function automatic int f_prod(input int a, input int c, input int cz, input int g, input int m);
        if (cz != 0 || a == 0) return 0;
        return (a * f_pow(g, c, m)) % m;
    endfunction

    function automatic string f_tag(input int a, input int c, input int cz, input int g, input int m);
        if (cz != 0) return "R3";
        if (a == 0) return "R2";
        if (c == 0) return "R7";
        if (f_log(a, g, m) + c >= m - 1) return "R8";
        return "R1";
    endfunction

    task automatic check(input int k, input string tag, input int gv, input int gr,
                         input int ev, input int er);
        n_cmp++;
        if (gv != ev || gr != er) begin
            n_bad++;
            $display("FAIL %s m=%0d: got vld=%0d res=%0d, expected vld=%0d res=%0d",
                     tag, MODS[k], gv, gr, ev, er);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            int er;
            er = (p2_v[k] != 0) ? p2_e[k] : held[k];
            check(k, (p2_v[k] != 0) ? {"R4/", p2_t[k]} : "R4/R5",
                  int'(b_ovld[k]), int'(b_prod[k]), p2_v[k], er);
            if (p2_v[k] != 0) held[k] = p2_e[k];
            p2_v[k] = p1_v[k]; p2_e[k] = p1_e[k]; p2_t[k] = p1_t[k];
            p1_v[k] = s_vld[k];
            p1_e[k] = f_prod(s_a[k], s_c[k], s_cz[k], ROOTS[k], MODS[k]);
            p1_t[k] = f_tag(s_a[k], s_c[k], s_cz[k], ROOTS[k], MODS[k]);
            b_vld[k]  = (s_vld[k] != 0);
            b_opd[k]  = 6'(s_a[k]);
            b_cidx[k] = 6'(s_c[k]);
            b_cz[k]   = (s_cz[k] != 0);
        end
    endtask

    task automatic idle_all();
        for (int k = 0; k < NI; k++) begin
            s_vld[k] = 0; s_a[k] = 0; s_c[k] = 0; s_cz[k] = 0;
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < NI; k++) begin
            b_vld[k] = 1'b0; b_opd[k] = '0; b_cidx[k] = '0; b_cz[k] = 1'b0;
            p1_v[k] = 0; p1_e[k] = 0; p2_v[k] = 0; p2_e[k] = 0; held[k] = 0;
            p1_t[k] = "R1"; p2_t[k] = "R1";
        end
        idle_all();
        repeat (3) @(negedge clk);
        // R6: reset state of every instance.
        for (int k = 0; k < NI; k++) check(k, "R6", int'(b_ovld[k]), int'(b_prod[k]), 0, 0);
        rst = 1'b0;

        // Exhaustive back-to-back sweep per modulus (R1, R2, R7, R8).
        for (int k = 0; k < NI; k++) begin
            for (int a = 0; a < MODS[k]; a++) begin
                for (int c = 0; c < MODS[k] - 1; c++) begin
                    idle_all();
                    s_vld[k] = 1; s_a[k] = a; s_c[k] = c;
                    tick();
                end
            end
            idle_all();
            repeat (3) tick();
        end

        // Directed: flagged zero coefficient with largest exponent (R3).
        for (int k = 0; k < NI; k++) begin
            for (int a = 1; a < MODS[k]; a++) begin
                idle_all();
                s_vld[k] = 1; s_a[k] = a; s_c[k] = MODS[k] - 2; s_cz[k] = 1;
                tick();
            end
        end
        idle_all();
        repeat (3) tick();

        // Random mix with gaps in valid (R5 holds checked on idle cycles).
        for (int n = 0; n < 3000; n++) begin
            for (int k = 0; k < NI; k++) begin
                s_vld[k] = (($urandom % 4) != 0) ? 1 : 0;
                s_a[k]   = (($urandom % 8) == 0) ? 0 : int'($urandom % MODS[k]);
                s_c[k]   = int'($urandom % (MODS[k] - 1));
                s_cz[k]  = (($urandom % 8) == 0) ? 1 : 0;
            end
            tick();
        end
        idle_all();
        repeat (4) tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule